// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This block decides when a chip that shares its external bus with other agents may drive the bus pins. It works in one of three ownership modes. In master mode it holds the bus and lends it when an outside agent asks. In slave mode it holds nothing at rest and borrows the bus for each access. In partial-share mode it negotiates only for one shared chip-select region and keeps every other region to itself.

At every change of owner, the strobe lines are parked at their idle (negated) level before any driver turns off, and they are still idle when a driver turns on. The agent that gives up the bus and the agent that takes it therefore show the same levels at the moment of handover. A bus cycle engine uses the block by raising an access request with a region number, waiting for the go indication, driving its strobe requests, and pulsing done at the end.

Top module: `busown_ctrl`

## Requirements
- R1: The mode is captured from `strap_slave` while `rst` is high and held after reset (`mode_o` encoding: 0 master, 1 slave, 2 partial-share). After reset in master mode, `bus_oe` and every `ctl_oe` bit are 1 and `ctl_lvl` equals `NEG_LVL` (default 3'b111). After reset in slave mode, they are 0 and `ctl_lvl` still equals `NEG_LVL`.
- R2: A write (`cfg_wr`) with `cfg_partial`=1 moves master mode to partial-share, and one with 0 moves partial-share back to master. A write made while the sequencer is idle-owned takes effect on that clock edge. A write made during any other activity is held and applied at the first idle cycle. Writes in slave mode are ignored.
- R3: In slave mode, a pending access raises `own_req` on the next edge with the outputs still off. The edge after `own_gnt` enables the outputs with strobes negated for exactly one cycle. `acc_go` follows on the edge after that.
- R4: After `acc_done` in slave mode, the block holds strobes negated with outputs on for one cycle, then turns the outputs off for one cycle with `own_req` still high, and then drops `own_req`.
- R5: In master mode, an external request seen while idle gives one negated cycle with outputs on, then one cycle with outputs off and no grant, and then `ext_gnt`. When the request drops, the grant is removed and the outputs come back with strobes negated for one cycle before the block goes idle.
- R6: In master mode, a pending external request wins over a pending own access when the block is idle. A running access is never cut short: the handover starts on the edge that takes `acc_done`.
- R7: In partial-share mode, an access to region `SHARED_RGN` (default 2) uses the slave request, grant, negate and release sequence, with the outputs kept on. An access to any other region starts on the next edge with `own_req` low.
- R8: In partial-share mode, `bus_oe` stays 1 at all times, and `ext_req` produces no grant.
- R9: Each `ctl_lvl` bit shows its negated level from `NEG_LVL` unless an access is running. During an access it shows the active level (the inverted negated level) when the matching `strb_in` bit is 1.
- R10: `ext_gnt` and `bus_oe` are never both 1, and `acc_go` is never 1 without `bus_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the mode strap is sampled while it is high |
| strap_slave | input | 1 | Static mode strap: 1 slave, 0 master |
| cfg_wr | input | 1 | Software mode-write strobe |
| cfg_partial | input | 1 | Write data: 1 select partial-share, 0 select master |
| acc_req | input | 1 | An external access is pending |
| acc_region | input | RGN_W | Chip-select region of the pending access |
| acc_done | input | 1 | The running access completes this cycle |
| strb_in | input | NCTL | Per-line strobe requests from the cycle engine (1 = assert) |
| ext_req | input | 1 | Another agent requests the bus (master mode) |
| ext_gnt | output | 1 | Bus lent to the other agent |
| own_req | output | 1 | This chip requests the bus (slave and shared region) |
| own_gnt | input | 1 | Grant for `own_req` |
| acc_go | output | 1 | The access may run; strobes follow `strb_in` |
| bus_oe | output | 1 | Address/data output enable |
| ctl_oe | output | NCTL | Per-line strobe output enables |
| ctl_lvl | output | NCTL | Per-line strobe output levels |
| mode_o | output | 2 | Current mode |

## Verification
The bench targets the cycle order of each handover. A design that drops the enables in the same cycle it negates the strobes would show `bus_oe` low one cycle early. A design that drops the request with the drivers still on would show `own_req` low while `bus_oe` is high. A design that starts an access on the grant edge would raise `acc_go` without the negated cycle. The bench also checks three arbitration cases: a simultaneous own access and external request must hand the bus away, a request that arrives mid-access must wait for `acc_done`, and a partial-share write issued mid-access must not change the mode until the block is idle. In slave mode the mode write and `ext_req` must leave `mode_o` and `ext_gnt` untouched, and in partial-share mode a non-shared region must never raise `own_req`.

// File: rtl/busown_pkg.sv
package busown_pkg;

  typedef enum logic [1:0] {
    MD_MASTER  = 2'd0,
    MD_SLAVE   = 2'd1,
    MD_PARTIAL = 2'd2
  } own_mode_e;

  typedef enum logic [3:0] {
    ST_OFF,   // not owned, drivers off
    ST_REQ,   // request raised, waiting for grant
    ST_ACQ,   // grant seen, drivers on, strobes parked
    ST_HOME,  // owned and idle, strobes parked
    ST_BUSY,  // access running
    ST_RNEG,  // release: strobes parked, drivers on
    ST_ROFF,  // release: drivers off, request still held
    ST_LENT,  // bus lent to the other agent
    ST_TAKE   // retake: drivers on, strobes parked
  } own_state_e;

  typedef struct packed {
    logic oe;
    logic req;
    logic gnt;
    logic act;
  } own_out_t;

  function automatic own_out_t own_decode(own_state_e st, own_mode_e md, logic arb);
    own_out_t o;
    o = '0;
    case (st)
      ST_OFF:  o.oe = 1'b0;
      ST_REQ:  begin o.oe = (md == MD_PARTIAL); o.req = 1'b1; end
      ST_ACQ:  begin o.oe = 1'b1; o.req = 1'b1; end
      ST_HOME: o.oe = 1'b1;
      ST_BUSY: begin o.oe = 1'b1; o.req = arb; o.act = 1'b1; end
      ST_RNEG: begin o.oe = 1'b1; o.req = arb; end
      ST_ROFF: begin o.oe = (md == MD_PARTIAL); o.req = arb; end
      ST_LENT: o.gnt = 1'b1;
      ST_TAKE: o.oe = 1'b1;
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/busown_mode.sv
module busown_mode
  import busown_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      strap_slave,
  input  logic      cfg_wr,
  input  logic      cfg_partial,
  input  logic      quiet,
  output own_mode_e mode_q
);

  logic pend_q;
  logic pend_val_q;
  logic wr_val;
  logic apply;

  always_comb begin
    wr_val = cfg_wr ? cfg_partial : pend_val_q;
    apply  = (mode_q != MD_SLAVE) && quiet && (cfg_wr || pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= strap_slave ? MD_SLAVE : MD_MASTER;
      pend_q     <= 1'b0;
      pend_val_q <= 1'b0;
    end else if (mode_q != MD_SLAVE) begin
      if (apply) begin
        mode_q <= wr_val ? MD_PARTIAL : MD_MASTER;
        pend_q <= 1'b0;
      end else if (cfg_wr) begin
        pend_q     <= 1'b1;
        pend_val_q <= cfg_partial;
      end
    end
  end

endmodule

// File: rtl/busown_seq.sv
module busown_seq
  import busown_pkg::*;
#(
  parameter int RGN_W      = 2,
  parameter int SHARED_RGN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_slave,
  input  own_mode_e        mode,
  input  logic             acc_req,
  input  logic [RGN_W-1:0] acc_region,
  input  logic             acc_done,
  input  logic             ext_req,
  input  logic             own_gnt,
  output own_out_t         out_d,
  output own_out_t         out_q,
  output logic             quiet
);

  localparam logic [RGN_W-1:0] SHARED = RGN_W'(SHARED_RGN);

  own_state_e st_q, st_d;
  logic       arb_q, arb_d;
  own_state_e rst_st;
  own_mode_e  rst_md;

  always_comb begin
    rst_st = strap_slave ? ST_OFF : ST_HOME;
    rst_md = strap_slave ? MD_SLAVE : MD_MASTER;
  end

  always_comb begin
    st_d  = st_q;
    arb_d = arb_q;
    case (st_q)
      ST_OFF: begin
        if (acc_req) begin
          st_d  = ST_REQ;
          arb_d = 1'b1;
        end
      end
      ST_HOME: begin
        if ((mode == MD_MASTER) && ext_req) begin
          st_d  = ST_RNEG;
          arb_d = 1'b0;
        end else if (acc_req) begin
          if ((mode == MD_PARTIAL) && (acc_region == SHARED)) begin
            st_d  = ST_REQ;
            arb_d = 1'b1;
          end else begin
            st_d  = ST_BUSY;
            arb_d = 1'b0;
          end
        end
      end
      ST_REQ:  if (own_gnt) st_d = ST_ACQ;
      ST_ACQ:  st_d = ST_BUSY;
      ST_BUSY: begin
        if (acc_done) begin
          if (arb_q || ((mode == MD_MASTER) && ext_req)) st_d = ST_RNEG;
          else                                           st_d = ST_HOME;
        end
      end
      ST_RNEG: st_d = ST_ROFF;
      ST_ROFF: begin
        if (!arb_q) begin
          st_d = ST_LENT;
        end else begin
          st_d  = (mode == MD_SLAVE) ? ST_OFF : ST_HOME;
          arb_d = 1'b0;
        end
      end
      ST_LENT: if (!ext_req) st_d = ST_TAKE;
      ST_TAKE: st_d = ST_HOME;
      default: st_d = rst_st;
    endcase
  end

  always_comb begin
    out_d = own_decode(st_d, mode, arb_d);
    quiet = (st_q == ST_HOME) && (st_d == ST_HOME);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= rst_st;
      arb_q <= 1'b0;
      out_q <= own_decode(rst_st, rst_md, 1'b0);
    end else begin
      st_q  <= st_d;
      arb_q <= arb_d;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/busown_pins.sv
module busown_pins #(
  parameter int              NCTL    = 3,
  parameter logic [NCTL-1:0] NEG_LVL = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_slave,
  input  logic            oe_d,
  input  logic            act_d,
  input  logic [NCTL-1:0] strb_in,
  output logic [NCTL-1:0] ctl_oe,
  output logic [NCTL-1:0] ctl_lvl
);

  for (genvar i = 0; i < NCTL; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_oe[i]  <= !strap_slave;
        ctl_lvl[i] <= NEG_LVL[i];
      end else begin
        ctl_oe[i]  <= oe_d;
        ctl_lvl[i] <= (act_d && strb_in[i]) ? !NEG_LVL[i] : NEG_LVL[i];
      end
    end
  end

endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
  import busown_pkg::*;
#(
  parameter int              RGN_W      = 2,
  parameter int              SHARED_RGN = 2,
  parameter int              NCTL       = 3,
  parameter logic [NCTL-1:0] NEG_LVL    = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_slave,
  input  logic             cfg_wr,
  input  logic             cfg_partial,
  input  logic             acc_req,
  input  logic [RGN_W-1:0] acc_region,
  input  logic             acc_done,
  input  logic [NCTL-1:0]  strb_in,
  input  logic             ext_req,
  output logic             ext_gnt,
  output logic             own_req,
  input  logic             own_gnt,
  output logic             acc_go,
  output logic             bus_oe,
  output logic [NCTL-1:0]  ctl_oe,
  output logic [NCTL-1:0]  ctl_lvl,
  output logic [1:0]       mode_o
);

  own_mode_e mode;
  own_out_t  out_d, out_q;
  logic      quiet;

  busown_mode u_mode (
    .clk         (clk),
    .rst         (rst),
    .strap_slave (strap_slave),
    .cfg_wr      (cfg_wr),
    .cfg_partial (cfg_partial),
    .quiet       (quiet),
    .mode_q      (mode)
  );

  busown_seq #(
    .RGN_W      (RGN_W),
    .SHARED_RGN (SHARED_RGN)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .strap_slave (strap_slave),
    .mode        (mode),
    .acc_req     (acc_req),
    .acc_region  (acc_region),
    .acc_done    (acc_done),
    .ext_req     (ext_req),
    .own_gnt     (own_gnt),
    .out_d       (out_d),
    .out_q       (out_q),
    .quiet       (quiet)
  );

  busown_pins #(
    .NCTL    (NCTL),
    .NEG_LVL (NEG_LVL)
  ) u_pins (
    .clk         (clk),
    .rst         (rst),
    .strap_slave (strap_slave),
    .oe_d        (out_d.oe),
    .act_d       (out_d.act),
    .strb_in     (strb_in),
    .ctl_oe      (ctl_oe),
    .ctl_lvl     (ctl_lvl)
  );

  always_comb begin
    ext_gnt = out_q.gnt;
    own_req = out_q.req;
    acc_go  = out_q.act;
    bus_oe  = out_q.oe;
    mode_o  = mode;
  end

endmodule

// File: rtl/busown_ctrl_chk.sv
module busown_ctrl_chk #(
  parameter int              NCTL    = 3,
  parameter logic [NCTL-1:0] NEG_LVL = '1
) (
  input logic            clk,
  input logic            rst,
  input logic            ext_gnt,
  input logic            own_req,
  input logic            acc_go,
  input logic            bus_oe,
  input logic [NCTL-1:0] ctl_lvl,
  input logic [1:0]      mode_o
);

  // R4
  oe_off_parked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe) |-> (ctl_lvl == NEG_LVL) && ($past(ctl_lvl) == NEG_LVL));

  // R3
  oe_on_parked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_oe) |-> (ctl_lvl == NEG_LVL));

  // R4
  req_after_off_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd1) && $fell(own_req)) |-> !$past(bus_oe));

  // R10
  no_fight_chk: assert property (@(posedge clk) disable iff (rst)
    ext_gnt |-> !bus_oe);

  // R10
  go_driven_chk: assert property (@(posedge clk) disable iff (rst)
    acc_go |-> bus_oe);

  // R8
  partial_driven_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> bus_oe);

  // R2
  slave_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |=> (mode_o == 2'd1));

  // R9
  idle_parked_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_go |-> (ctl_lvl == NEG_LVL));

endmodule

bind busown_ctrl busown_ctrl_chk #(.NCTL(NCTL), .NEG_LVL(NEG_LVL)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_gnt (ext_gnt),
  .own_req (own_req),
  .acc_go  (acc_go),
  .bus_oe  (bus_oe),
  .ctl_lvl (ctl_lvl),
  .mode_o  (mode_o)
);

// File: tb/busown_ctrl_test.sv
`timescale 1ns/1ps
module busown_ctrl_test;

  localparam int         RGN_W = 2;
  localparam int         NCTL  = 3;
  localparam logic [2:0] NEG   = 3'b111;
  localparam logic [2:0] STRB  = 3'b101;
  localparam logic [2:0] ACT   = 3'b010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_slave = 1'b0;
  logic cfg_wr = 1'b0, cfg_partial = 1'b0;
  logic acc_req = 1'b0, acc_done = 1'b0, ext_req = 1'b0, own_gnt = 1'b0;
  logic [RGN_W-1:0] acc_region = '0;
  logic [NCTL-1:0]  strb_in = STRB;
  logic ext_gnt, own_req, acc_go, bus_oe;
  logic [NCTL-1:0] ctl_oe, ctl_lvl;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  busown_ctrl uut (
    .clk(clk), .rst(rst), .strap_slave(strap_slave),
    .cfg_wr(cfg_wr), .cfg_partial(cfg_partial),
    .acc_req(acc_req), .acc_region(acc_region), .acc_done(acc_done),
    .strb_in(strb_in), .ext_req(ext_req), .ext_gnt(ext_gnt),
    .own_req(own_req), .own_gnt(own_gnt), .acc_go(acc_go),
    .bus_oe(bus_oe), .ctl_oe(ctl_oe), .ctl_lvl(ctl_lvl), .mode_o(mode_o)
  );

  // inputs {acc_req, shared_rgn, ext_req, own_gnt, acc_done}
  // expect {bus_oe, own_req, ext_gnt, acc_go, strobes_parked}
  localparam int NV = 21;
  localparam logic [9:0] VEC [NV] = '{
    10'b00000_10001,  // R1 idle owned
    10'b10000_10010,  // R9 access starts
    10'b10000_10010,
    10'b00001_10001,
    10'b00100_10001,  // R5 park
    10'b00100_00001,  // R5 drivers off
    10'b10100_00101,  // R5 grant
    10'b10100_00101,
    10'b10000_10001,  // R5 retake parked
    10'b10000_10001,
    10'b10000_10010,
    10'b00101_10001,  // R6 request waits for done
    10'b00100_00001,
    10'b00100_00101,
    10'b00000_10001,
    10'b00000_10001,
    10'b10100_10001,  // R6 external wins
    10'b10100_00001,
    10'b10000_00101,
    10'b10000_10001,
    10'b00000_10001
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic a, logic [RGN_W-1:0] rg, logic e, logic g, logic d);
    acc_req = a; acc_region = rg; ext_req = e; own_gnt = g; acc_done = d;
    @(posedge clk); #1;
  endtask

  task automatic outs(string tag, logic oe, logic rq, logic gn, logic go, logic [2:0] lvl);
    chk(tag, {3'b0, bus_oe, own_req, ext_gnt, acc_go, 1'b0}, {3'b0, oe, rq, gn, go, 1'b0});
    chk(tag, {5'b0, ctl_lvl}, {5'b0, lvl});
    chk(tag, {5'b0, ctl_oe}, {5'b0, {3{oe}}});
  endtask

  task automatic do_reset(logic s);
    rst = 1'b1; strap_slave = s; cfg_wr = 1'b0;
    acc_req = 0; ext_req = 0; own_gnt = 0; acc_done = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 master reset
    do_reset(1'b0);
    outs("R1 master reset", 1, 0, 0, 0, NEG);
    chk("R1 mode master", {6'b0, mode_o}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      v = VEC[i];
      drive(v[9], v[8] ? 2'd2 : 2'd0, v[7], v[6], v[5]);
      outs($sformatf("R5/R6 vector %0d", i), v[4], v[3], v[2], v[1], v[0] ? NEG : ACT);
    end

    // R2 write during access is deferred
    drive(1, 0, 0, 0, 0);
    cfg_wr = 1; cfg_partial = 1;
    drive(1, 0, 0, 0, 0);
    cfg_wr = 0;
    chk("R2 deferred while busy", {6'b0, mode_o}, 8'd0);
    drive(0, 0, 0, 0, 1);
    chk("R2 still deferred", {6'b0, mode_o}, 8'd0);
    drive(0, 0, 0, 0, 0);
    chk("R2 applied when idle", {6'b0, mode_o}, 8'd2);

    // R7 non-shared region: no arbitration
    drive(1, 1, 0, 0, 0);
    outs("R7 plain region", 1, 0, 0, 1, ACT);
    drive(0, 0, 0, 0, 1);
    outs("R7 plain done", 1, 0, 0, 0, NEG);
    // R7 shared region
    drive(1, 2, 0, 0, 0);
    outs("R7 shared request", 1, 1, 0, 0, NEG);
    drive(1, 2, 0, 0, 0);
    outs("R7 wait grant", 1, 1, 0, 0, NEG);
    drive(1, 2, 0, 1, 0);
    outs("R7 parked acquire", 1, 1, 0, 0, NEG);
    drive(0, 2, 0, 1, 0);
    outs("R7 access", 1, 1, 0, 1, ACT);
    drive(0, 2, 0, 1, 1);
    outs("R7 release park", 1, 1, 0, 0, NEG);
    drive(0, 0, 0, 1, 0);
    outs("R7 release hold", 1, 1, 0, 0, NEG);
    drive(0, 0, 0, 0, 0);
    outs("R7 request dropped", 1, 0, 0, 0, NEG);
    // R8 external request ignored
    drive(0, 0, 1, 0, 0);
    drive(0, 0, 1, 0, 0);
    outs("R8 no grant in partial", 1, 0, 0, 0, NEG);
    // R2 back to master
    cfg_wr = 1; cfg_partial = 0;
    drive(0, 0, 0, 0, 0);
    cfg_wr = 0;
    chk("R2 back to master", {6'b0, mode_o}, 8'd0);

    // R1 slave reset
    do_reset(1'b1);
    outs("R1 slave reset", 0, 0, 0, 0, NEG);
    chk("R1 mode slave", {6'b0, mode_o}, 8'd1);
    strap_slave = 1'b0;
    cfg_wr = 1; cfg_partial = 1;
    drive(0, 0, 1, 0, 0);
    cfg_wr = 0;
    drive(0, 0, 1, 0, 0);
    chk("R2 write ignored in slave", {6'b0, mode_o}, 8'd1);
    outs("R1 strap not resampled", 0, 0, 0, 0, NEG);
    // R3 acquire
    drive(1, 0, 0, 0, 0);
    outs("R3 request off", 0, 1, 0, 0, NEG);
    drive(1, 0, 0, 1, 0);
    outs("R3 parked on", 1, 1, 0, 0, NEG);
    drive(1, 0, 0, 1, 0);
    outs("R3 go", 1, 1, 0, 1, ACT);
    // R4 release
    drive(0, 0, 0, 1, 1);
    outs("R4 park", 1, 1, 0, 0, NEG);
    drive(0, 0, 0, 1, 0);
    outs("R4 drivers off", 0, 1, 0, 0, NEG);
    drive(0, 0, 0, 0, 0);
    outs("R4 request dropped", 0, 0, 0, 0, NEG);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule